// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Element

This block is one tile of a programmable logic fabric. A table of 2^K configuration cells forms a K-input lookup table. The K table inputs are the address, and the addressed cell is the result. Because every cell can be written, the table can implement any Boolean function of its K inputs.

A crosspoint matrix picks the table inputs. Its columns are the external signals plus the element's own registered value, and each crossing has its own enable bit. A D flip-flop captures the table result on every rising clock edge. A mode bit then chooses whether the element output is the flip-flop value or the table result taken directly.

All configuration bits are held in one serial shift chain. Software loads the chain one bit per clock while the load enable is high. The element keeps evaluating the bits it currently holds, so its output is only meaningful once a complete image has been loaded.

Top module: `clb_tile`

## Requirements
- R1: The table result is the cell whose index is the table-input vector, with table input 0 as the least significant address bit. A table of all ones always yields 1.
- R2: With the default K = 4 there are 16 cells, and loading the cells of AND, 4-input parity or 3-of-4 majority reproduces that function. A two-input XOR on inputs 0 and 1 uses the cell values 0, 1, 1, 0 for the index values 00, 01, 10, 11.
- R3: Table input r is 1 when at least one enabled crossing in row r has a high source; several enabled crossings combine as an OR. A row with no enabled crossing gives 0.
- R4: In combinational mode (mode bit 0) the element output follows the table result within the same cycle.
- R5: In registered mode (mode bit 1) the element output equals the table result sampled at the previous rising clock edge.
- R6: Source column EXT_IN (the last column) carries the flip-flop value, so a routed feedback closes a sequential loop through the table.
- R7: While `cfg_load` is high, the chain shifts one bit per rising edge, taking `cfg_bit` at its low end. While `cfg_load` is low, the configuration holds whatever `cfg_bit` does.
- R8: The image is sent most significant bit first, in this order: routing bits, starting with row K-1 column EXT_IN and ending with row 0 column 0; then the table cells from cell 2^K-1 down to cell 0; then the mode bit last.
- R9: An active-low asynchronous reset clears the flip-flop at once and leaves every configuration bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flip-flop and the configuration chain |
| rst_n | input | 1 | Active-low asynchronous reset of the flip-flop |
| cfg_load | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data, most significant bit first |
| ext_in | input | EXT_IN | External signals offered to the crosspoint matrix |
| elem_out | output | 1 | Element output, either the table result or the flip-flop value |

## Verification
The bench builds the element with K = 4 and four external sources. This gives a 37-bit chain and five routing columns, so a full table function can be swept through all 16 input patterns in both output modes. The feedback column drives a toggle loop, which shows the flip-flop clearing on reset while the loaded image survives. Extra rows carry a two-source OR and an unrouted input, which shows how several enabled crossings combine and what an empty row gives.

// File: rtl/clb_pkg.sv
package clb_pkg;
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

    function automatic int chain_len(input int k, input int srcs);
        return k * srcs + (1 << k) + 1;
    endfunction
endpackage

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain
    import clb_pkg::*;
#(
    parameter int K    = 4,
    parameter int SRCS = 5
) (
    input  logic                 clk,
    input  logic                 cfg_load,
    input  logic                 cfg_bit,
    output logic [K*SRCS-1:0]    route,
    output logic [(1<<K)-1:0]    table_bits,
    output out_mode_e            mode
);
    localparam int ROUTE_W = K * SRCS;
    localparam int TBL_W   = 1 << K;
    localparam int TOTAL   = chain_len(K, SRCS);

    typedef struct packed {
        logic [TOTAL-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.bits = {st_q.bits[TOTAL-2:0], cfg_bit};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign route      = st_q.bits[TOTAL-1 -: ROUTE_W];
    assign table_bits = st_q.bits[TBL_W:1];
    assign mode       = out_mode_e'(st_q.bits[0]);

    // Configuration holds while no load is in progress
    assert_cfg_hold_R7: assert property (@(posedge clk)
        !cfg_load |=> $stable(st_q.bits));
endmodule

// File: rtl/clb_xbar.sv
module clb_xbar #(
    parameter int K    = 4,
    parameter int SRCS = 5
) (
    input  logic [K*SRCS-1:0] route,
    input  logic [SRCS-1:0]   src,
    output logic [K-1:0]      lut_in
);
    for (genvar r = 0; r < K; r++) begin : g_row
        logic [SRCS-1:0] hit;
        assign hit       = route[r*SRCS +: SRCS] & src;
        assign lut_in[r] = |hit;

        always_comb begin
            if (route[r*SRCS +: SRCS] == '0) begin
                assert_unrouted_zero_R3: assert (lut_in[r] == 1'b0);
            end
        end
    end
endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] table_bits,
    input  logic [K-1:0]      addr,
    output logic              lut_out
);
    always_comb begin
        lut_out = table_bits[addr];
    end

    always_comb begin
        if (&table_bits) begin
            assert_all_ones_R1: assert (lut_out == 1'b1);
        end
        if (table_bits == '0) begin
            assert_all_zeros_R1: assert (lut_out == 1'b0);
        end
    end
endmodule

// File: rtl/clb_tile.sv
module clb_tile
    import clb_pkg::*;
#(
    parameter int K      = 4,
    parameter int EXT_IN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_bit,
    input  logic [EXT_IN-1:0] ext_in,
    output logic              elem_out
);
    localparam int SRCS = EXT_IN + 1;

    typedef struct packed {
        logic ff;
    } tile_t;

    tile_t st_d, st_q;

    logic [K*SRCS-1:0]  route;
    logic [(1<<K)-1:0]  table_bits;
    out_mode_e          mode;
    logic [SRCS-1:0]    src;
    logic [K-1:0]       lut_in;
    logic               lut_out;

    clb_cfg_chain #(.K(K), .SRCS(SRCS)) u_chain (
        .clk        (clk),
        .cfg_load   (cfg_load),
        .cfg_bit    (cfg_bit),
        .route      (route),
        .table_bits (table_bits),
        .mode       (mode)
    );

    assign src = {st_q.ff, ext_in};

    clb_xbar #(.K(K), .SRCS(SRCS)) u_xbar (
        .route  (route),
        .src    (src),
        .lut_in (lut_in)
    );

    clb_lut #(.K(K)) u_lut (
        .table_bits (table_bits),
        .addr       (lut_in),
        .lut_out    (lut_out)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ff = lut_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        elem_out = (mode == OUT_REG) ? st_q.ff : lut_out;
    end

    // Registered mode presents the result of the previous edge
    assert_reg_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OUT_REG && !cfg_load) |=> (elem_out == $past(lut_out)));

    // Reset holds the flip-flop cleared
    assert_reset_clear_R9: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (st_q.ff == 1'b0));
endmodule

// File: tb/clb_tile_tb.sv
module clb_tile_tb;
    localparam int K      = 4;
    localparam int EXT_IN = 4;
    localparam int SRCS   = EXT_IN + 1;
    localparam int RW     = K * SRCS;
    localparam int TW     = 1 << K;
    localparam int TOTAL  = RW + TW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic cfg_load = 1'b0;
    logic cfg_bit = 1'b0;
    logic [EXT_IN-1:0] ext_in = '0;
    logic elem_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    clb_tile #(.K(K), .EXT_IN(EXT_IN)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_bit  (cfg_bit),
        .ext_in   (ext_in),
        .elem_out (elem_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] ident_route();
        logic [RW-1:0] r = '0;
        for (int i = 0; i < K; i++) r[i*SRCS + i] = 1'b1;
        return r;
    endfunction

    function automatic logic [TW-1:0] func_table(input int f);
        logic [TW-1:0] t = '0;
        for (int a = 0; a < TW; a++) begin
            int ones = $countones(a[K-1:0]);
            case (f)
                0: t[a] = (a == TW - 1);
                1: t[a] = ones[0];
                2: t[a] = (ones >= 3);
                default: t[a] = a[0] ^ a[1];
            endcase
        end
        return t;
    endfunction

    task automatic load(input logic [RW-1:0] r, input logic [TW-1:0] t, input logic m);
        logic [TOTAL-1:0] img = {r, t, m};
        for (int i = 0; i < K; i++)
            if ($countones(r[i*SRCS +: SRCS]) > 1)
                $display("WARNING: table input %0d driven by several crosspoints", i);
        @(negedge clk);
        cfg_load = 1'b1;
        for (int i = TOTAL - 1; i >= 0; i--) begin
            cfg_bit = img[i];
            @(negedge clk);
        end
        cfg_load = 1'b0;
    endtask

    // R1 R2 R4 R5 R8: sweep a function through all patterns in both modes
    task automatic test_function(input int f, input string req);
        logic [TW-1:0] t = func_table(f);
        load(ident_route(), t, 1'b0);
        for (int v = 0; v < TW; v++) begin
            @(negedge clk);
            ext_in = v[EXT_IN-1:0];
            #1 check({req, " R4 comb"}, elem_out, t[v]);
        end
        load(ident_route(), t, 1'b1);
        for (int v = 0; v < TW; v++) begin
            @(negedge clk);
            ext_in = v[EXT_IN-1:0];
            @(posedge clk);
            #1 check({req, " R5 reg"}, elem_out, t[v]);
        end
    endtask

    // R2: two-input XOR cells 0,1,1,0
    task automatic test_xor2();
        logic [RW-1:0] r = '0;
        r[0*SRCS + 0] = 1'b1;
        r[1*SRCS + 1] = 1'b1;
        load(r, func_table(3), 1'b0);
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            ext_in = v[EXT_IN-1:0];
            #1 check("R2 xor2", elem_out, v[0] ^ v[1]);
        end
    endtask

    // R3: wired OR of two sources and unrouted rows read as 0
    task automatic test_wired_or();
        logic [RW-1:0] r = '0;
        r[0*SRCS + 0] = 1'b1;
        r[0*SRCS + 1] = 1'b1;
        load(r, 16'hAAAA, 1'b0);
        for (int v = 0; v < TW; v++) begin
            @(negedge clk);
            ext_in = v[EXT_IN-1:0];
            #1 check("R3 wired-or", elem_out, v[0] | v[1]);
        end
        load('0, 16'h0001, 1'b0);
        for (int v = 0; v < TW; v += 5) begin
            @(negedge clk);
            ext_in = v[EXT_IN-1:0];
            #1 check("R3 unrouted", elem_out, 1'b1);
        end
    endtask

    // R6 R9: feedback toggle, reset clears flip-flop, image retained
    task automatic test_feedback_reset();
        logic [RW-1:0] r = '0;
        logic prev;
        r[0*SRCS + EXT_IN] = 1'b1;
        load(r, 16'h5555, 1'b1);
        @(negedge clk);
        prev = elem_out;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R6 toggle", elem_out, ~prev);
            prev = elem_out;
        end
        rst_n = 1'b0;
        #1 check("R9 reset clears", elem_out, 1'b0);
        @(negedge clk);
        check("R9 reset held", elem_out, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        #1 check("R9 image kept", elem_out, 1'b1);
        @(posedge clk);
        #1 check("R9 image kept", elem_out, 1'b0);
    endtask

    // R7: wiggling the serial input without load changes nothing
    task automatic test_hold();
        load(ident_route(), func_table(0), 1'b0);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            cfg_bit = i[0];
        end
        for (int v = 0; v < TW; v++) begin
            @(negedge clk);
            ext_in = v[EXT_IN-1:0];
            #1 check("R7 hold", elem_out, v == TW - 1);
        end
    endtask

    initial begin
        #2 rst_n = 1'b0;
        load(ident_route(), 16'h0000, 1'b1);
        #1 check("R9 reset state", elem_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        test_function(0, "R2 and");
        test_function(1, "R2 parity");
        test_function(2, "R8 majority");
        test_xor2();
        test_wired_or();
        test_feedback_reset();
        test_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule